// File: doc/BRIEF.md
# Flow-Through Burst SRAM with Zero Bus Turnaround

This block is a synchronous static memory with a flow-through read path. It shares one bidirectional data bus for reads and writes and needs no idle cycle when the direction changes. Every control and address input is captured on a rising clock edge while the clock enable is high. A read drives its word onto the bus during the cycle right after the capturing edge. A write leaves the bus free in that same cycle and takes its data from the bus on the next enabled edge. Because of this one-cycle lag between a write's address and its data, a read may follow a write, or a write a read, on consecutive edges with no turnaround gap.

A single loaded address can start a burst of up to four beats. The loaded address sets the upper address bits. The two low bits step either linearly or in interleaved order, and the order is chosen when the address is loaded. Each 9-bit byte lane has its own write select. Low clock enable freezes the whole pipeline. The output enable acts asynchronously on the drivers only. Two chip selects of opposite polarity can deselect the device. A sleep input parks the device: the bus floats and no operation is pending, and the memory contents are kept.

Top module: `ft_burst_sram`

## Requirements
- R1: While reset is asserted, and after it is released, the device does not drive `dq` until a read is loaded.
- R2: At an enabled edge with `advance`=0, `chip_sel`=1, `chip_sel_n`=0 and `write`=0, the word at `addr` is driven on `dq` during the following cycle, provided `out_en`=1.
- R3: At an enabled edge with `advance`=0 and `write`=1 (device selected), `dq` is not driven in the following cycle whatever `out_en` is. The word on `dq` at the next enabled edge is stored at that address.
- R4: Reads and writes can alternate on consecutive enabled edges with no idle cycle. A read loaded on the edge that captures a write's data, to that same address, returns the new data.
- R5: With `order_il`=0 at load, beat n of a burst (n = 0..3, one beat per enabled edge with `advance`=1) uses address low bits (base + n) mod 4, and the upper bits stay unchanged. A fifth beat wraps back to the base.
- R6: With `order_il`=1 at load, beat n uses low bits base XOR n. `order_il` is ignored on advance edges.
- R7: `lane_we[i]` enables the write of bits `dq[9i+8:9i]`. A write with `lane_we`=0 leaves the memory unchanged.
- R8: While `clk_en`=0, no input is sampled, the burst state and the driven read word are held, and a pending write's data capture waits for the next enabled edge.
- R9: `out_en`=0 floats `dq` without changing the operation. A burst loaded with `out_en`=0 continues and drives normally once `out_en` returns to 1.
- R10: A load edge with `chip_sel`=0 or `chip_sel_n`=1 deselects the device. The device then drives nothing and writes nothing, including on later advance edges, until a new load.
- R11: `sleep`=1 floats `dq` at once and cancels any operation on the next rising edge, whatever `clk_en` is. The memory is kept, and after sleep ends the bus stays floating until a new read is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Clock qualifier; 0 freezes the pipeline |
| chip_sel | input | 1 | Active-high chip select, sampled at load |
| chip_sel_n | input | 1 | Active-low chip select, sampled at load |
| advance | input | 1 | 0 = load a new address and operation, 1 = next burst beat |
| write | input | 1 | At load: 1 = write, 0 = read |
| lane_we | input | 2 | Per-lane write selects for the beat being issued |
| order_il | input | 1 | At load: 0 = linear, 1 = interleaved burst order |
| addr | input | 6 | Word address |
| out_en | input | 1 | Asynchronous output driver enable |
| sleep | input | 1 | Sleep request; floats the bus and cancels operations |
| dq | inout | 18 | Shared data bus, two lanes of 9 bits |

## Verification
If the burst counter or order flag is wrong, the word read on the following cycle is a neighbour's value within the same aligned group of four. A wrongly timed write capture either stores the bus word of the wrong cycle or drives while the master drives. Either fault shows at the first read of that location, at most a few cycles later. A stall that leaks state shows as a changed read word during the frozen cycles. A lost sleep or deselect shows at once as a driven bus where it should float.

// File: rtl/ftb_pkg.sv
package ftb_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two address bits for beat n of a burst from base.
  function automatic logic [1:0] beat_low(input logic [1:0] base,
                                          input logic [1:0] n,
                                          input logic il);
    return il ? (base ^ n) : (base + n);
  endfunction

endpackage

// File: rtl/ftb_burst_seq.sv
module ftb_burst_seq
  import ftb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              sleep,
  input  logic              sel_ok,
  input  logic              advance,
  input  logic              write,
  input  logic              order_il,
  input  logic [LANES-1:0]  lane_we,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op_q,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LANES-1:0]  beat_mask,
  output logic              wr_fire
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              il_q, il_d;
  logic [LANES-1:0]  mask_q, mask_d;
  op_e               op_d;

  // Next-state logic
  always_comb begin
    op_d   = op_q;
    base_d = base_q;
    cnt_d  = cnt_q;
    il_d   = il_q;
    mask_d = mask_q;
    if (sleep) begin
      op_d = OP_IDLE;
    end else if (clk_en) begin
      mask_d = lane_we;
      if (!advance) begin
        op_d   = sel_ok ? (write ? OP_WRITE : OP_READ) : OP_IDLE;
        base_d = addr;
        cnt_d  = 2'd0;
        il_d   = order_il;
      end else begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= 2'd0;
      il_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      op_q   <= op_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      il_q   <= il_d;
      mask_q <= mask_d;
    end
  end

  assign beat_addr = {base_q[ADDR_W-1:2], beat_low(base_q[1:0], cnt_q, il_q)};
  assign beat_mask = mask_q;
  assign wr_fire   = clk_en && !sleep && (op_q == OP_WRITE);

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && advance && !sleep) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !advance && !sleep) |=> (cnt_q == 2'd0 && base_q == $past(addr)));

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !sleep) |=> ($stable(op_q) && $stable(cnt_q) && $stable(base_q)));

  // R11
  sleep_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (op_q == OP_IDLE));

  // R10
  desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !advance && !sleep && !sel_ok) |=> (op_q == OP_IDLE));

endmodule

// File: rtl/ftb_lane_array.sv
module ftb_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    wr_fire,
  input  logic [LANES-1:0]        wr_mask,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_fire && wr_mask[g]) begin
        mem[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[addr];
  end

endmodule

// File: rtl/ft_burst_sram.sv
module ft_burst_sram
  import ftb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clk_en,
  input  logic                    chip_sel,
  input  logic                    chip_sel_n,
  input  logic                    advance,
  input  logic                    write,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    order_il,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    out_en,
  input  logic                    sleep,
  inout  wire  [LANES*LANE_W-1:0] dq
);

  localparam int DATA_W = LANES * LANE_W;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  op_e               op_q;
  logic [ADDR_W-1:0] beat_addr;
  logic [LANES-1:0]  beat_mask;
  logic              wr_fire;
  logic [DATA_W-1:0] rdata;
  logic              dq_oe;

  ftb_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clk_en    (clk_en),
    .sleep     (sleep),
    .sel_ok    (chip_sel && !chip_sel_n),
    .advance   (advance),
    .write     (write),
    .order_il  (order_il),
    .lane_we   (lane_we),
    .addr      (addr),
    .op_q      (op_q),
    .beat_addr (beat_addr),
    .beat_mask (beat_mask),
    .wr_fire   (wr_fire)
  );

  ftb_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .wr_fire (wr_fire),
    .wr_mask (beat_mask),
    .addr    (beat_addr),
    .wdata   (dq),
    .rdata   (rdata)
  );

  assign dq_oe = out_en && !sleep && (op_q == OP_READ);
  assign dq    = dq_oe ? rdata : {DATA_W{1'bz}};

  // R3
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_q == OP_WRITE) |-> !dq_oe);

endmodule

// File: tb/ft_burst_sram_test.sv
`timescale 1ns/100ps
module ft_burst_sram_test;

  localparam int DW = 18;
  localparam logic [DW-1:0] FLOAT = '1;
  localparam logic [1:0] C_ADV = 2'd0, C_RD = 2'd1, C_WR = 2'd2, C_DS = 2'd3;

  logic clk = 1'b0;
  logic rst_n, clk_en, chip_sel, chip_sel_n, advance, write, order_il;
  logic out_en, sleep, tb_drv;
  logic [1:0] lane_we;
  logic [5:0] addr;
  logic [DW-1:0] tb_bus;
  wire  [DW-1:0] dq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  assign dq = tb_drv ? tb_bus : {DW{1'bz}};
  for (genvar i = 0; i < DW; i++) begin : g_pull
    pullup (dq[i]);
  end

  ft_burst_sram uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .chip_sel(chip_sel),
    .chip_sel_n(chip_sel_n), .advance(advance), .write(write),
    .lane_we(lane_we), .order_il(order_il), .addr(addr),
    .out_en(out_en), .sleep(sleep), .dq(dq)
  );

  typedef struct packed {
    logic [1:0]    cmd;
    logic [1:0]    lanes;
    logic          oe;
    logic [5:0]    a;
    logic          drv;
    logic [DW-1:0] bus;
    logic [3:0]    req;
    logic [DW-1:0] exp;
  } vec_t;

  localparam vec_t VECS [16] = '{
    {C_WR,  2'b11, 1'b1, 6'h10, 1'b0, 18'h00000, 4'd3,  FLOAT},     // R3
    {C_WR,  2'b11, 1'b1, 6'h11, 1'b1, 18'h1A5A5, 4'd3,  FLOAT},     // R3
    {C_RD,  2'b00, 1'b1, 6'h10, 1'b1, 18'h0C3C3, 4'd4,  18'h1A5A5}, // R4
    {C_WR,  2'b11, 1'b1, 6'h12, 1'b0, 18'h00000, 4'd3,  FLOAT},     // R3
    {C_RD,  2'b00, 1'b1, 6'h11, 1'b1, 18'h2F0F0, 4'd4,  18'h0C3C3}, // R4
    {C_RD,  2'b00, 1'b1, 6'h12, 1'b0, 18'h00000, 4'd2,  18'h2F0F0}, // R2
    {C_WR,  2'b01, 1'b1, 6'h10, 1'b0, 18'h00000, 4'd3,  FLOAT},     // R3
    {C_RD,  2'b00, 1'b1, 6'h10, 1'b1, 18'h3FFFF, 4'd7,  18'h1A5FF}, // R7
    {C_WR,  2'b00, 1'b1, 6'h11, 1'b0, 18'h00000, 4'd3,  FLOAT},     // R3
    {C_RD,  2'b00, 1'b1, 6'h11, 1'b1, 18'h00000, 4'd7,  18'h0C3C3}, // R7
    {C_WR,  2'b10, 1'b1, 6'h12, 1'b0, 18'h00000, 4'd3,  FLOAT},     // R3
    {C_RD,  2'b00, 1'b1, 6'h12, 1'b1, 18'h00000, 4'd7,  18'h000F0}, // R7
    {C_RD,  2'b00, 1'b0, 6'h10, 1'b0, 18'h00000, 4'd9,  FLOAT},     // R9
    {C_ADV, 2'b00, 1'b1, 6'h00, 1'b0, 18'h00000, 4'd9,  18'h0C3C3}, // R9
    {C_DS,  2'b11, 1'b1, 6'h13, 1'b0, 18'h00000, 4'd10, FLOAT},     // R10
    {C_ADV, 2'b11, 1'b1, 6'h00, 1'b0, 18'h00000, 4'd10, FLOAT}      // R10
  };

  function automatic logic [DW-1:0] dat(input int a);
    return DW'(a * 1299 + 161);
  endfunction

  task automatic tick(input logic ce, input logic [1:0] cmd, input logic il,
                      input logic [1:0] ln, input logic [5:0] a,
                      input logic drv, input logic [DW-1:0] bus, input logic oe);
    @(negedge clk);
    clk_en = ce; chip_sel = 1'b1; chip_sel_n = (cmd == C_DS);
    advance = (cmd == C_ADV); write = (cmd == C_WR); order_il = il;
    lane_we = ln; addr = a; tb_drv = drv; tb_bus = bus; out_en = oe;
    @(posedge clk);
    #0.5 tb_drv = 1'b0;
    #1;
  endtask

  task automatic check(input string tag, input logic [DW-1:0] exp);
    checks++;
    if (dq !== exp) begin
      fails++;
      $display("FAIL %s: dq=%h expected %h", tag, dq, exp);
    end
  endtask

  initial begin
    #100000;
    checks++; fails++;
    $display("FAIL watchdog: run did not end, actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clk_en = 1'b1; chip_sel = 1'b1; chip_sel_n = 1'b0;
    advance = 1'b1; write = 1'b0; order_il = 1'b0; lane_we = 2'b00;
    addr = '0; out_en = 1'b1; sleep = 1'b0; tb_drv = 1'b0; tb_bus = '0;
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", FLOAT);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 after reset", FLOAT);

    for (int i = 0; i < 16; i++) begin
      tick(1'b1, VECS[i].cmd, 1'b0, VECS[i].lanes, VECS[i].a,
           VECS[i].drv, VECS[i].bus, VECS[i].oe);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].exp);
    end

    // Fill 0x20..0x27 with two linear write bursts (R5)
    tick(1'b1, C_WR, 1'b0, 2'b11, 6'h20, 1'b0, '0, 1'b1);
    for (int k = 0; k < 3; k++) tick(1'b1, C_ADV, 1'b0, 2'b11, '0, 1'b1, dat(32 + k), 1'b1);
    tick(1'b1, C_WR, 1'b0, 2'b11, 6'h24, 1'b1, dat(35), 1'b1);
    for (int k = 0; k < 3; k++) tick(1'b1, C_ADV, 1'b0, 2'b11, '0, 1'b1, dat(36 + k), 1'b1);

    // R5: linear read burst from 0x22 with wrap to base
    tick(1'b1, C_RD, 1'b0, 2'b00, 6'h22, 1'b1, dat(39), 1'b1);
    check("R5 linear beat0", dat(34));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R5 linear beat1", dat(35));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R5 linear beat2", dat(32));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R5 linear beat3", dat(33));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R5 linear wrap", dat(34));

    // R6: interleaved from 0x21, order pin dropped on advance edges
    tick(1'b1, C_RD, 1'b1, 2'b00, 6'h21, 1'b0, '0, 1'b1); check("R6 il21 beat0", dat(33));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R6 il21 beat1", dat(32));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R6 il21 beat2", dat(35));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R6 il21 beat3", dat(34));
    tick(1'b1, C_RD, 1'b1, 2'b00, 6'h26, 1'b0, '0, 1'b1); check("R6 il26 beat0", dat(38));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R6 il26 beat1", dat(39));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R6 il26 beat2", dat(36));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R6 il26 beat3", dat(37));

    // R8: stall during a read burst
    tick(1'b1, C_RD, 1'b0, 2'b00, 6'h23, 1'b0, '0, 1'b1); check("R8 read start", dat(35));
    tick(1'b0, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R8 stall 1", dat(35));
    tick(1'b0, C_RD, 1'b0, 2'b00, 6'h10, 1'b0, '0, 1'b1); check("R8 stall 2", dat(35));
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R8 resume", dat(32));

    // R8: stall between a write command and its data
    tick(1'b1, C_WR, 1'b0, 2'b11, 6'h30, 1'b0, '0, 1'b1); check("R8 write cycle float", FLOAT);
    tick(1'b0, C_ADV, 1'b0, 2'b11, '0, 1'b1, 18'h11111, 1'b1); check("R8 stalled write float", FLOAT);
    tick(1'b1, C_RD, 1'b0, 2'b00, 6'h30, 1'b1, 18'h22222, 1'b1); check("R8 R4 deferred write", 18'h22222);

    // R11: sleep floats at once, cancels, keeps memory
    tick(1'b1, C_RD, 1'b0, 2'b00, 6'h20, 1'b0, '0, 1'b1); check("R11 pre-sleep read", dat(32));
    @(negedge clk) sleep = 1'b1;
    #0.5 check("R11 float on sleep", FLOAT);
    tick(1'b1, C_RD, 1'b0, 2'b00, 6'h21, 1'b0, '0, 1'b1); check("R11 in sleep 1", FLOAT);
    tick(1'b0, C_RD, 1'b0, 2'b00, 6'h21, 1'b0, '0, 1'b1); check("R11 in sleep 2", FLOAT);
    @(negedge clk) sleep = 1'b0;
    tick(1'b1, C_ADV, 1'b0, 2'b00, '0, 1'b0, '0, 1'b1); check("R11 after sleep float", FLOAT);
    tick(1'b1, C_RD, 1'b0, 2'b00, 6'h21, 1'b0, '0, 1'b1); check("R11 memory kept", dat(33));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule